// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small fully associative store that sits beside a direct-mapped primary cache. Lines that the primary cache throws out are kept here for a while. When the primary cache misses, the controller presents the full block address on the lookup port. A hit returns the line and its dirty flag in the same cycle, so no main-memory access is needed. Misses that come from two blocks fighting over one primary index are the ones this store absorbs.

On a hit the line goes back to the primary cache. The primary line it replaces arrives on the insert port in that same cycle and takes the freed slot, so the swap finishes in one clock. When every slot holds a valid line, a new line pushes out the line that was inserted longest ago. If that line is dirty, it is offered on a write-back port with a valid/ready handshake. While that write-back waits, new inserts are held off. Each entry stores the whole block address (tag plus index) as its key.

Top module: `vcTop`

## Requirements
- R1: After reset, every slot is empty: no lookup hits, `wbValid` is 0 and `insertReady` is 1.
- R2: A line accepted on the insert port is found by a later lookup of the same block address in the same cycle as the lookup, with the inserted data and dirty flag on `lookupData` and `lookupDirty`.
- R3: A lookup of a block address that no valid slot holds gives `lookupHit` = 0.
- R4: A lookup hit with no insert in the same cycle removes the line at the clock edge, so a repeat lookup of that address misses.
- R5: A lookup hit together with an accepted insert of a different address stores the inserted line in the freed slot. The returned line leaves the buffer, and the inserted line counts as the newest entry for displacement order.
- R6: The buffer holds DEPTH lines (default 16). An insert into a full buffer displaces the line whose last insertion is oldest.
- R7: A displaced line is offered on the write-back port (`wbValid` = 1, with its address and data) only when its dirty flag is 1. A clean displaced line is dropped.
- R8: While `wbValid` = 1 and `wbReady` = 0, `wbAddr` and `wbData` hold steady and `insertReady` = 0. An insert presented then is not stored. `wbValid` drops after the edge where `wbReady` = 1, unless a new dirty line is displaced at that edge.
- R9: An insert and a lookup of the same block address in the same cycle give `lookupHit` = 1 with the insert's data and dirty flag. That line is handed straight back and is not stored.
- R10: An insert into a buffer that has at least one empty slot displaces no line.
- R11: With `lookupValid` = 0, `lookupHit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Primary-cache miss, search requested |
| lookupAddr | input | ADDR_W | Block address searched |
| lookupHit | output | 1 | Line found (or forwarded from the insert port) |
| lookupData | output | DATA_W | Returned line data |
| lookupDirty | output | 1 | Returned line's dirty flag |
| insertValid | input | 1 | Evicted primary line presented |
| insertAddr | input | ADDR_W | Evicted line's block address |
| insertData | input | DATA_W | Evicted line's data |
| insertDirty | input | 1 | Evicted line is newer than memory |
| insertReady | output | 1 | Insert accepted this cycle |
| wbValid | output | 1 | Dirty displaced line awaiting memory |
| wbAddr | output | ADDR_W | Write-back block address |
| wbData | output | DATA_W | Write-back line data |
| wbReady | input | 1 | Memory side takes the write-back |

## Verification
Lookup and insert can land in the same cycle, and the two address relations behave differently. With the same address, the inserted line must be forwarded and never stored. With a hit on a different address, the inserted line must take over the vacated slot. Both cases are driven by raising both valids in one cycle. The forwarded line is judged by its combinational outputs and by a later lookup that misses. The swap is judged by lookups after the edge and by pushing enough new lines to show that the swapped-in line outlives every older entry. A displacement under write-back stall is also provoked, to show that inserts are refused while the write-back holds steady.

// File: rtl/vcPkg.sv
package vcPkg;
  typedef struct packed {
    logic wrEn;    // write insert port into wrSlot
    logic clrEn;   // invalidate clrSlot
    logic wbLoad;  // copy wrSlot's old content into write-back register
  } vcStrobes_t;
endpackage

// File: rtl/vcDatapath.sv
module vcDatapath
  import vcPkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  vcStrobes_t        st,
  input  logic [IDX_W-1:0]  wrSlot,
  input  logic [IDX_W-1:0]  clrSlot,
  input  logic              fwdSel,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [ADDR_W-1:0] insertAddr,
  input  logic [DATA_W-1:0] insertData,
  input  logic              insertDirty,
  output logic [DEPTH-1:0]  matchVec,
  output logic [DEPTH-1:0]  validVec,
  output logic [DEPTH-1:0]  dirtyVec,
  output logic              addrEq,
  output logic [DATA_W-1:0] lookupData,
  output logic              lookupDirty,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);
  logic [ADDR_W-1:0] tagQ  [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [DEPTH-1:0]  validQ, dirtyQ;
  logic [ADDR_W-1:0] wbAddrQ;
  logic [DATA_W-1:0] wbDataQ;
  logic [DATA_W-1:0] hitData;
  logic              hitDirty;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gMatch
      assign matchVec[g] = validQ[g] && (tagQ[g] == lookupAddr);
    end
  endgenerate

  assign addrEq   = (insertAddr == lookupAddr);
  assign validVec = validQ;
  assign dirtyVec = dirtyQ;

  always_comb begin
    hitData  = '0;
    hitDirty = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (matchVec[i]) begin
        hitData  = hitData | dataQ[i];
        hitDirty = hitDirty | dirtyQ[i];
      end
    end
  end

  assign lookupData  = fwdSel ? insertData  : hitData;
  assign lookupDirty = fwdSel ? insertDirty : hitDirty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else begin
      if (st.clrEn) begin
        validQ[clrSlot] <= 1'b0;
        dirtyQ[clrSlot] <= 1'b0;
      end
      if (st.wrEn) begin
        validQ[wrSlot] <= 1'b1;
        dirtyQ[wrSlot] <= insertDirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.wrEn) begin
      tagQ[wrSlot]  <= insertAddr;
      dataQ[wrSlot] <= insertData;
    end
    if (st.wbLoad) begin
      wbAddrQ <= tagQ[wrSlot];
      wbDataQ <= dataQ[wrSlot];
    end
  end

  assign wbAddr = wbAddrQ;
  assign wbData = wbDataQ;
endmodule

// File: rtl/vcControl.sv
module vcControl
  import vcPkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             insertValid,
  input  logic             addrEq,
  input  logic [DEPTH-1:0] matchVec,
  input  logic [DEPTH-1:0] validVec,
  input  logic [DEPTH-1:0] dirtyVec,
  input  logic             wbReady,
  output vcStrobes_t       st,
  output logic [IDX_W-1:0] wrSlot,
  output logic [IDX_W-1:0] clrSlot,
  output logic             fwdSel,
  output logic             lookupHit,
  output logic             insertReady,
  output logic             wbValid
);
  // Age rank per slot: a permutation of 0..DEPTH-1, highest = newest insert.
  logic [IDX_W-1:0] rankQ [DEPTH];
  logic [IDX_W-1:0] hitIdx, freeIdx, oldestIdx;
  logic             anyFree, fwd, arrHit, store, wbValidQ;

  always_comb begin
    hitIdx    = '0;
    freeIdx   = '0;
    oldestIdx = '0;
    anyFree   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
      if (rankQ[i] == '0) oldestIdx = IDX_W'(i);
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  assign fwd         = lookupValid && insertValid && addrEq;
  assign arrHit      = lookupValid && (|matchVec) && !fwd;
  assign insertReady = fwd || !wbValidQ || wbReady;
  assign store       = insertValid && insertReady && !fwd;

  always_comb begin
    st        = '0;
    st.wrEn   = store;
    st.clrEn  = arrHit && !store;
    wrSlot    = arrHit ? hitIdx : (anyFree ? freeIdx : oldestIdx);
    clrSlot   = hitIdx;
    st.wbLoad = store && !arrHit && !anyFree && dirtyVec[oldestIdx];
  end

  assign fwdSel    = fwd;
  assign lookupHit = fwd || arrHit;
  assign wbValid   = wbValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValidQ <= 1'b0;
    end else if (st.wbLoad) begin
      wbValidQ <= 1'b1;
    end else if (wbReady) begin
      wbValidQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) rankQ[i] <= IDX_W'(i);
    end else if (st.wrEn) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (IDX_W'(i) == wrSlot) rankQ[i] <= IDX_W'(DEPTH - 1);
        else if (rankQ[i] > rankQ[wrSlot]) rankQ[i] <= rankQ[i] - 1'b1;
      end
    end
  end
endmodule

// File: rtl/vcTop.sv
module vcTop
  import vcPkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              lookupHit,
  output logic [DATA_W-1:0] lookupData,
  output logic              lookupDirty,
  input  logic              insertValid,
  input  logic [ADDR_W-1:0] insertAddr,
  input  logic [DATA_W-1:0] insertData,
  input  logic              insertDirty,
  output logic              insertReady,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData,
  input  logic              wbReady
);
  vcStrobes_t       st;
  logic [IDX_W-1:0] wrSlot, clrSlot;
  logic [DEPTH-1:0] matchVec, validVec, dirtyVec;
  logic             addrEq, fwdSel;

  vcControl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .insertValid(insertValid), .addrEq(addrEq),
    .matchVec(matchVec), .validVec(validVec), .dirtyVec(dirtyVec),
    .wbReady(wbReady), .st(st), .wrSlot(wrSlot), .clrSlot(clrSlot),
    .fwdSel(fwdSel), .lookupHit(lookupHit), .insertReady(insertReady),
    .wbValid(wbValid)
  );

  vcDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .wrSlot(wrSlot), .clrSlot(clrSlot),
    .fwdSel(fwdSel), .lookupAddr(lookupAddr), .insertAddr(insertAddr),
    .insertData(insertData), .insertDirty(insertDirty),
    .matchVec(matchVec), .validVec(validVec), .dirtyVec(dirtyVec),
    .addrEq(addrEq), .lookupData(lookupData), .lookupDirty(lookupDirty),
    .wbAddr(wbAddr), .wbData(wbData)
  );
endmodule

// File: rtl/vcChecker.sv
module vcChecker #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              lookupValid,
  input logic [ADDR_W-1:0] lookupAddr,
  input logic              lookupHit,
  input logic [DATA_W-1:0] lookupData,
  input logic              lookupDirty,
  input logic              insertValid,
  input logic [ADDR_W-1:0] insertAddr,
  input logic [DATA_W-1:0] insertData,
  input logic              insertDirty,
  input logic              insertReady,
  input logic              wbValid,
  input logic [ADDR_W-1:0] wbAddr,
  input logic [DATA_W-1:0] wbData,
  input logic              wbReady
);
  assert_wb_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |=> (wbValid && $stable(wbAddr) && $stable(wbData)));

  assert_stall_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    !insertReady |-> (wbValid && !wbReady));

  assert_forward_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && insertValid && lookupAddr == insertAddr) |->
      (lookupHit && lookupData == insertData && lookupDirty == insertDirty));

  assert_idle_nohit_R11: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !lookupHit);

  assert_take_removes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && lookupHit && !insertValid) |=>
      !(lookupValid && lookupHit && lookupAddr == $past(lookupAddr) &&
        !(insertValid && insertAddr == lookupAddr)));
endmodule

bind vcTop vcChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
  .lookupHit(lookupHit), .lookupData(lookupData), .lookupDirty(lookupDirty),
  .insertValid(insertValid), .insertAddr(insertAddr), .insertData(insertData),
  .insertDirty(insertDirty), .insertReady(insertReady), .wbValid(wbValid),
  .wbAddr(wbAddr), .wbData(wbData), .wbReady(wbReady)
);

// File: tb/vcTop_tb.sv
module vcTop_tb_top;
  localparam int ADDR_W = 26;
  localparam int DATA_W = 64;
  localparam int DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              lookupValid = 1'b0;
  logic [ADDR_W-1:0] lookupAddr = '0;
  logic              lookupHit;
  logic [DATA_W-1:0] lookupData;
  logic              lookupDirty;
  logic              insertValid = 1'b0;
  logic [ADDR_W-1:0] insertAddr = '0;
  logic [DATA_W-1:0] insertData = '0;
  logic              insertDirty = 1'b0;
  logic              insertReady;
  logic              wbValid;
  logic [ADDR_W-1:0] wbAddr;
  logic [DATA_W-1:0] wbData;
  logic              wbReady = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vcTop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (.*);

  function automatic logic [DATA_W-1:0] dataOf(input logic [ADDR_W-1:0] a);
    return 64'hA5C3_0000_0000_0000 ^ DATA_W'(a) ^ (DATA_W'(a) << 32);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; lookupValid = 1'b0; insertValid = 1'b0; wbReady = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic ins(input logic [ADDR_W-1:0] a, input bit dirty);
    @(negedge clk);
    insertValid = 1'b1; insertAddr = a; insertData = dataOf(a); insertDirty = dirty;
    @(posedge clk); #1;
    insertValid = 1'b0;
  endtask

  // lookup without a clock edge: no state change
  task automatic peek(input logic [ADDR_W-1:0] a, input bit expHit, input string req);
    @(negedge clk);
    lookupValid = 1'b1; lookupAddr = a;
    #1;
    check(lookupHit == expHit, req, "peek hit", 64'(lookupHit), 64'(expHit));
    if (expHit && lookupHit)
      check(lookupData == dataOf(a), req, "peek data", lookupData, dataOf(a));
    lookupValid = 1'b0;
  endtask

  task automatic fill(input logic [ADDR_W-1:0] base, input bit firstDirty);
    for (int i = 0; i < DEPTH; i++) ins(base + ADDR_W'(i), (i == 0) && firstDirty);
  endtask

  task automatic testReset();
    doReset();
    #1;
    check(wbValid == 1'b0, "R1", "wbValid after reset", 64'(wbValid), 0);
    check(insertReady == 1'b1, "R1", "insertReady after reset", 64'(insertReady), 1);
    peek(26'h0, 1'b0, "R1");
    peek(26'h123, 1'b0, "R1");
  endtask

  task automatic testInsertLookup();
    doReset();
    ins(26'h0AB, 1'b1);
    peek(26'h0AB, 1'b1, "R2");
    @(negedge clk);
    lookupValid = 1'b1; lookupAddr = 26'h0AB; #1;
    check(lookupDirty == 1'b1, "R2", "dirty flag returned", 64'(lookupDirty), 1);
    lookupValid = 1'b0;
    peek(26'h0AC, 1'b0, "R3");
    @(negedge clk);
    lookupAddr = 26'h0AB; #1;
    check(lookupHit == 1'b0, "R11", "hit with lookupValid low", 64'(lookupHit), 0);
    // take it: lookup across a clock edge, no insert
    @(negedge clk);
    lookupValid = 1'b1; lookupAddr = 26'h0AB; #1;
    check(lookupHit == 1'b1, "R4", "take hit", 64'(lookupHit), 1);
    @(posedge clk); #1;
    lookupValid = 1'b0;
    peek(26'h0AB, 1'b0, "R4");
  endtask

  task automatic testForward();
    doReset();
    @(negedge clk);
    lookupValid = 1'b1; lookupAddr = 26'h3C;
    insertValid = 1'b1; insertAddr = 26'h3C; insertData = dataOf(26'h3C); insertDirty = 1'b1;
    #1;
    check(lookupHit == 1'b1, "R9", "forward hit", 64'(lookupHit), 1);
    check(lookupData == dataOf(26'h3C), "R9", "forward data", lookupData, dataOf(26'h3C));
    check(lookupDirty == 1'b1, "R9", "forward dirty", 64'(lookupDirty), 1);
    @(posedge clk); #1;
    lookupValid = 1'b0; insertValid = 1'b0;
    peek(26'h3C, 1'b0, "R9");
  endtask

  task automatic testCleanDisplace();
    doReset();
    fill(26'h100, 1'b0);
    for (int i = 0; i < DEPTH; i += 5) peek(26'h100 + ADDR_W'(i), 1'b1, "R6");
    ins(26'h200, 1'b0);
    check(wbValid == 1'b0, "R7", "clean displaced line not written back", 64'(wbValid), 0);
    peek(26'h100, 1'b0, "R6");
    peek(26'h101, 1'b1, "R6");
    peek(26'h200, 1'b1, "R6");
  endtask

  task automatic testDirtyStall();
    doReset();
    fill(26'h100, 1'b1);
    wbReady = 1'b0;
    ins(26'h200, 1'b0);
    check(wbValid == 1'b1, "R7", "dirty displaced line offered", 64'(wbValid), 1);
    check(wbAddr == 26'h100, "R7", "write-back address", 64'(wbAddr), 64'h100);
    check(wbData == dataOf(26'h100), "R7", "write-back data", wbData, dataOf(26'h100));
    check(insertReady == 1'b0, "R8", "insertReady while stalled", 64'(insertReady), 0);
    ins(26'h300, 1'b0);
    check(wbValid == 1'b1, "R8", "wbValid held", 64'(wbValid), 1);
    check(wbAddr == 26'h100, "R8", "wbAddr stable", 64'(wbAddr), 64'h100);
    peek(26'h300, 1'b0, "R8");
    peek(26'h101, 1'b1, "R8");
    @(negedge clk) wbReady = 1'b1;
    @(posedge clk); #1;
    check(wbValid == 1'b0, "R8", "wbValid after ready", 64'(wbValid), 0);
    check(insertReady == 1'b1, "R8", "insertReady after drain", 64'(insertReady), 1);
  endtask

  task automatic testSwapOrder();
    doReset();
    fill(26'h100, 1'b0);
    // swap: hit 0x105 while inserting 0x400
    @(negedge clk);
    lookupValid = 1'b1; lookupAddr = 26'h105;
    insertValid = 1'b1; insertAddr = 26'h400; insertData = dataOf(26'h400); insertDirty = 1'b0;
    #1;
    check(lookupHit == 1'b1, "R5", "swap hit", 64'(lookupHit), 1);
    check(lookupData == dataOf(26'h105), "R5", "swap data", lookupData, dataOf(26'h105));
    check(insertReady == 1'b1, "R5", "swap insert accepted", 64'(insertReady), 1);
    @(posedge clk); #1;
    lookupValid = 1'b0; insertValid = 1'b0;
    peek(26'h105, 1'b0, "R5");
    peek(26'h400, 1'b1, "R5");
    // free one slot, then insert: nothing displaced
    @(negedge clk);
    lookupValid = 1'b1; lookupAddr = 26'h107;
    @(posedge clk); #1;
    lookupValid = 1'b0;
    ins(26'h500, 1'b0);
    peek(26'h100, 1'b1, "R10");
    peek(26'h500, 1'b1, "R10");
    // 14 more inserts flush the 14 older lines; the swapped-in line survives
    for (int i = 0; i < DEPTH - 2; i++) ins(26'h600 + ADDR_W'(i), 1'b0);
    peek(26'h10F, 1'b0, "R5");
    peek(26'h100, 1'b0, "R6");
    peek(26'h400, 1'b1, "R5");
    ins(26'h700, 1'b0);
    peek(26'h400, 1'b0, "R6");
    peek(26'h500, 1'b1, "R6");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testInsertLookup();
    testForward();
    testCleanDisplace();
    testDirtyStall();
    testSwapOrder();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule